// File: doc/BRIEF.md
# Peer Snarf Reuse Predictor

This block sits beside an L2 cache controller and chooses where each evicted line goes. It records evicted line addresses in a small set-associative reuse table. When a recorded address misses in the L2 again, the table marks that line as one that returns. A later eviction of a marked line is offered to a peer L2 cache over the on-chip fabric instead of being written to the off-chip L3.

Each accepted eviction is broadcast as a snoop to every peer. The block holds its eviction input closed until every peer has answered. Any peer that already holds the line clean makes the writeback unnecessary, so the line is squashed. Otherwise a marked line goes to the lowest-numbered peer that reports room for it, and every other line takes the L3 path. A separate combinational helper is the recipient side of the exchange. A peer uses it to choose the way that takes a snarfed line: an invalid way if the set has one, otherwise a shared way.

Top module: `peer_snarf_predictor`

## Requirements
- R1: After reset, evict_ready is 1, dec_valid and snoop_req are 0, and the reuse table holds no entries.
- R2: An eviction whose address has no table entry allocates an entry with its reuse mark clear. Without a clean peer copy the decision is L3 (dec_kind 0), and a repeat eviction with no miss in between is L3 again.
- R3: A miss to an address that has a table entry sets that entry's reuse mark. The next eviction of that address, with some peer accepting and none clean, gives decision SNARF (dec_kind 1).
- R4: A miss to an address with no table entry changes nothing. Later evictions of that address behave as in R2.
- R5: If any peer responds with rsp_clean set, the decision is SQUASH (dec_kind 2). This holds whatever the reuse mark and the accept bits are.
- R6: A marked eviction for which no peer sets rsp_accept gives decision L3.
- R7: evict_ready is low from the cycle after an eviction is accepted until the edge that collects the last peer response. dec_valid pulses for exactly the one cycle after that edge, and evict_ready is high again in that cycle. Responses may arrive in any cycles, spread over several cycles.
- R8: snoop_req is high for exactly the one cycle after an eviction is accepted. snoop_addr then shows the accepted address.
- R9: The table has SETS sets of WAYS ways, and the low log2(SETS) address bits select the set. Allocation fills the lowest invalid way first. If no way is invalid, it takes the way least recently used by an eviction, where both an allocation and an eviction hit count as a use. Replacing an entry clears its reuse mark, and a single address never matches two ways.
- R10: When a miss and an eviction are accepted in the same cycle, the eviction decision uses the reuse mark as it stood before that edge, and the miss update is still kept. If the eviction's allocation replaces the entry the miss hit, the cleared mark wins.
- R11: The recipient way picker uses the state codes 0 = invalid, 1 = shared, 2 = exclusive, 3 = modified, with way w in bits [2w+1:2w]. It returns the lowest invalid way, or if there is none the lowest shared way, with rcv_ok = 1. With neither, rcv_ok is 0.
- R12: For a SNARF decision, dec_peer is the lowest-numbered peer whose response had rsp_accept set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_valid | input | 1 | Eviction offered |
| evict_addr | input | AW | Line address of the eviction |
| evict_ready | output | 1 | Eviction accepted when high together with evict_valid |
| miss_valid | input | 1 | L2 miss event |
| miss_addr | input | AW | Line address of the miss |
| snoop_req | output | 1 | One-cycle snoop broadcast to peers |
| snoop_addr | output | AW | Address being snooped |
| rsp_valid | input | NPEER | One response strobe per peer |
| rsp_clean | input | NPEER | Peer holds the line in a clean state |
| rsp_accept | input | NPEER | Peer has an invalid or shared way free for the line |
| dec_valid | output | 1 | Decision strobe |
| dec_kind | output | 2 | 0 = L3 writeback, 1 = snarf to peer, 2 = squash |
| dec_peer | output | PW | Target peer of a snarf |
| rcv_way_state | input | 2*RWAYS | Recipient set way states |
| rcv_way | output | RWW | Chosen recipient way |
| rcv_ok | output | 1 | A way was found |

## Verification
The two table updates that can fall in one cycle are a miss that sets a reuse mark and an eviction that reads the mark and may allocate over it. The bench drives both in the same accepted cycle, in a directed case on one address and at random over a small pool of addresses that crowd two sets. It then judges the result twice: the decision must reflect the mark before the edge, and the following eviction must reflect the miss update, or the clear if the allocation replaced that entry. Misses that arrive while responses are still being collected are also mixed in, so the table is shown to keep learning while the eviction port is closed.

// File: rtl/psp_pkg.sv
package psp_pkg;
  typedef enum logic [1:0] {
    DEC_L3     = 2'd0,
    DEC_SNARF  = 2'd1,
    DEC_SQUASH = 2'd2
  } dec_kind_e;

  typedef enum logic [1:0] {
    WS_INV = 2'd0,
    WS_SHR = 2'd1,
    WS_EXC = 2'd2,
    WS_MOD = 2'd3
  } way_st_e;
endpackage

// File: rtl/psp_reuse_table.sv
module psp_reuse_table #(
  parameter int AW   = 16,
  parameter int SETS = 128,
  parameter int WAYS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_en,
  input  logic [AW-1:0] ev_addr,
  output logic          ev_use,
  input  logic          mi_en,
  input  logic [AW-1:0] mi_addr
);
  localparam int IDXW = $clog2(SETS);
  localparam int TAGW = AW - IDXW;
  localparam int AGEW = $clog2(WAYS);

  logic            vld_q [SETS][WAYS];
  logic            use_q [SETS][WAYS];
  logic [AGEW-1:0] age_q [SETS][WAYS];
  logic [TAGW-1:0] tag_q [SETS][WAYS];

  logic [IDXW-1:0] e_set, m_set;
  logic [TAGW-1:0] e_tag, m_tag;
  logic [WAYS-1:0] e_hitv, m_hitv, e_freev;
  logic [AGEW-1:0] e_hway, e_vic, e_tgt, m_way;
  logic [AGEW-1:0] age_nx [WAYS];
  logic            e_hit, e_alloc, m_set_en;

  assign e_set = ev_addr[IDXW-1:0];
  assign e_tag = ev_addr[AW-1:IDXW];
  assign m_set = mi_addr[IDXW-1:0];
  assign m_tag = mi_addr[AW-1:IDXW];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign e_hitv[w]  = vld_q[e_set][w] && (tag_q[e_set][w] == e_tag);
    assign m_hitv[w]  = vld_q[m_set][w] && (tag_q[m_set][w] == m_tag);
    assign e_freev[w] = !vld_q[e_set][w];
  end

  assign e_hit    = |e_hitv;
  assign e_alloc  = ev_en && !e_hit;
  assign m_set_en = mi_en && (|m_hitv);

  // way selection: hit way, else lowest invalid, else oldest
  always_comb begin
    logic found;
    e_hway = '0;
    m_way  = '0;
    e_vic  = '0;
    found  = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (e_hitv[w]) e_hway = AGEW'(w);
      if (m_hitv[w]) m_way  = AGEW'(w);
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!found && e_freev[w]) begin
        e_vic = AGEW'(w);
        found = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[e_set][w] == AGEW'(WAYS - 1)) e_vic = AGEW'(w);
      end
    end
    e_tgt = e_hit ? e_hway : e_vic;
  end

  // recency update of the touched set
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (AGEW'(w) == e_tgt)                        age_nx[w] = '0;
      else if (age_q[e_set][w] < age_q[e_set][e_tgt]) age_nx[w] = age_q[e_set][w] + 1'b1;
      else                                          age_nx[w] = age_q[e_set][w];
    end
  end

  assign ev_use = e_hit && use_q[e_set][e_hway];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          use_q[s][w] <= 1'b0;
          age_q[s][w] <= AGEW'(w);
        end
      end
    end else begin
      if (ev_en) begin
        vld_q[e_set][e_tgt] <= 1'b1;
        for (int w = 0; w < WAYS; w++) age_q[e_set][w] <= age_nx[w];
      end
      if (m_set_en) use_q[m_set][m_way] <= 1'b1;
      if (e_alloc)  use_q[e_set][e_tgt] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ev_en) tag_q[e_set][e_tgt] <= e_tag;
  end

  // R9
  uniq_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_en |-> $onehot0(e_hitv));

  // R9
  alloc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    e_alloc |=> !use_q[$past(e_set)][$past(e_tgt)]);

  // R3
  miss_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_set_en && !(e_alloc && e_set == m_set && e_tgt == m_way))
      |=> use_q[$past(m_set)][$past(m_way)]);
endmodule

// File: rtl/psp_evict_ctrl.sv
module psp_evict_ctrl
  import psp_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NPEER = 3,
  parameter int PW    = (NPEER > 1) ? $clog2(NPEER) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evict_valid,
  input  logic [AW-1:0]    evict_addr,
  output logic             evict_ready,
  output logic             tbl_ev_en,
  input  logic             tbl_use,
  output logic             snoop_req,
  output logic [AW-1:0]    snoop_addr,
  input  logic [NPEER-1:0] rsp_valid,
  input  logic [NPEER-1:0] rsp_clean,
  input  logic [NPEER-1:0] rsp_accept,
  output logic             dec_valid,
  output logic [1:0]       dec_kind,
  output logic [PW-1:0]    dec_peer
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  st_e              st_q, st_n;
  logic [AW-1:0]    addr_q, addr_n;
  logic             mark_q, mark_n;
  logic [NPEER-1:0] got_q, got_n, cln_q, cln_n, acc_q, acc_n;
  logic             snp_q, snp_n, dv_q, dv_n;
  logic [1:0]       dk_q, dk_n;
  logic [PW-1:0]    dp_q, dp_n;
  logic             take;

  function automatic logic [PW-1:0] lowest(input logic [NPEER-1:0] v);
    lowest = '0;
    for (int i = NPEER - 1; i >= 0; i--) if (v[i]) lowest = PW'(i);
  endfunction

  assign take = evict_valid && (st_q == ST_IDLE);

  always_comb begin
    st_n   = st_q;
    addr_n = addr_q;
    mark_n = mark_q;
    got_n  = got_q;
    cln_n  = cln_q;
    acc_n  = acc_q;
    snp_n  = 1'b0;
    dv_n   = 1'b0;
    dk_n   = dk_q;
    dp_n   = dp_q;
    case (st_q)
      ST_IDLE: begin
        if (take) begin
          st_n   = ST_WAIT;
          addr_n = evict_addr;
          mark_n = tbl_use;
          got_n  = '0;
          cln_n  = '0;
          acc_n  = '0;
          snp_n  = 1'b1;
        end
      end
      default: begin
        got_n = got_q | rsp_valid;
        cln_n = cln_q | (rsp_valid & rsp_clean);
        acc_n = acc_q | (rsp_valid & rsp_accept);
        if (&got_n) begin
          st_n = ST_IDLE;
          dv_n = 1'b1;
          dp_n = '0;
          if (|cln_n) begin
            dk_n = DEC_SQUASH;
          end else if (mark_q && (|acc_n)) begin
            dk_n = DEC_SNARF;
            dp_n = lowest(acc_n);
          end else begin
            dk_n = DEC_L3;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      got_q <= '0;
      cln_q <= '0;
      acc_q <= '0;
      snp_q <= 1'b0;
      dv_q  <= 1'b0;
      dk_q  <= DEC_L3;
      dp_q  <= '0;
    end else begin
      st_q  <= st_n;
      got_q <= got_n;
      cln_q <= cln_n;
      acc_q <= acc_n;
      snp_q <= snp_n;
      dv_q  <= dv_n;
      dk_q  <= dk_n;
      dp_q  <= dp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      addr_q <= addr_n;
      mark_q <= mark_n;
    end
  end

  assign evict_ready = (st_q == ST_IDLE);
  assign tbl_ev_en   = take;
  assign snoop_req   = snp_q;
  assign snoop_addr  = addr_q;
  assign dec_valid   = dv_q;
  assign dec_kind    = dk_q;
  assign dec_peer    = dp_q;

  // R7
  snoop_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_q |-> !evict_ready);

  // R7
  dec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dv_q |=> !dv_q);

  // R8
  snoop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_q |=> !snp_q);

  // R6
  snarf_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_q && dk_q == DEC_SNARF) |-> mark_q);

  // R12
  snarf_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_q && dk_q == DEC_SNARF) |-> acc_q[dp_q]);

  // R5
  squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_q && (|cln_q)) |-> (dk_q == DEC_SQUASH));
endmodule

// File: rtl/psp_way_pick.sv
module psp_way_pick
  import psp_pkg::*;
#(
  parameter int RWAYS = 8,
  parameter int RWW   = (RWAYS > 1) ? $clog2(RWAYS) : 1
) (
  input  logic [2*RWAYS-1:0] way_state,
  output logic [RWW-1:0]     way_sel,
  output logic               way_ok
);
  logic [RWAYS-1:0] inv_v, shr_v;

  for (genvar w = 0; w < RWAYS; w++) begin : g_cls
    assign inv_v[w] = (way_state[2*w +: 2] == WS_INV);
    assign shr_v[w] = (way_state[2*w +: 2] == WS_SHR);
  end

  always_comb begin
    logic [RWW-1:0] inv_w, shr_w;
    inv_w = '0;
    shr_w = '0;
    for (int w = RWAYS - 1; w >= 0; w--) begin
      if (inv_v[w]) inv_w = RWW'(w);
      if (shr_v[w]) shr_w = RWW'(w);
    end
    way_ok  = (|inv_v) || (|shr_v);
    way_sel = (|inv_v) ? inv_w : shr_w;
  end

  always_comb begin
    // R11
    if (way_ok) begin
      pick_legal_chk: assert (way_state[2*way_sel +: 2] == WS_INV ||
                              (way_state[2*way_sel +: 2] == WS_SHR && !(|inv_v)));
    end
  end
endmodule

// File: rtl/peer_snarf_predictor.sv
module peer_snarf_predictor #(
  parameter int AW    = 16,
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int NPEER = 3,
  parameter int RWAYS = 8,
  parameter int PW    = (NPEER > 1) ? $clog2(NPEER) : 1,
  parameter int RWW   = (RWAYS > 1) ? $clog2(RWAYS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evict_valid,
  input  logic [AW-1:0]      evict_addr,
  output logic               evict_ready,
  input  logic               miss_valid,
  input  logic [AW-1:0]      miss_addr,
  output logic               snoop_req,
  output logic [AW-1:0]      snoop_addr,
  input  logic [NPEER-1:0]   rsp_valid,
  input  logic [NPEER-1:0]   rsp_clean,
  input  logic [NPEER-1:0]   rsp_accept,
  output logic               dec_valid,
  output logic [1:0]         dec_kind,
  output logic [PW-1:0]      dec_peer,
  input  logic [2*RWAYS-1:0] rcv_way_state,
  output logic [RWW-1:0]     rcv_way,
  output logic               rcv_ok
);
  logic tbl_ev_en, tbl_use;

  psp_reuse_table #(.AW(AW), .SETS(SETS), .WAYS(WAYS)) table_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_en   (tbl_ev_en),
    .ev_addr (evict_addr),
    .ev_use  (tbl_use),
    .mi_en   (miss_valid),
    .mi_addr (miss_addr)
  );

  psp_evict_ctrl #(.AW(AW), .NPEER(NPEER), .PW(PW)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evict_valid (evict_valid),
    .evict_addr  (evict_addr),
    .evict_ready (evict_ready),
    .tbl_ev_en   (tbl_ev_en),
    .tbl_use     (tbl_use),
    .snoop_req   (snoop_req),
    .snoop_addr  (snoop_addr),
    .rsp_valid   (rsp_valid),
    .rsp_clean   (rsp_clean),
    .rsp_accept  (rsp_accept),
    .dec_valid   (dec_valid),
    .dec_kind    (dec_kind),
    .dec_peer    (dec_peer)
  );

  psp_way_pick #(.RWAYS(RWAYS), .RWW(RWW)) pick_i (
    .way_state (rcv_way_state),
    .way_sel   (rcv_way),
    .way_ok    (rcv_ok)
  );
endmodule

// File: tb/peer_snarf_predictor_tb_top.sv
module peer_snarf_predictor_tb_top;
  localparam int AW = 16, SETS = 128, WAYS = 4, NPEER = 3, RWAYS = 8;
  localparam int IDXW = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic evict_valid, miss_valid;
  logic [AW-1:0] evict_addr, miss_addr, snoop_addr;
  logic evict_ready, snoop_req, dec_valid, rcv_ok;
  logic [NPEER-1:0] rsp_valid, rsp_clean, rsp_accept;
  logic [1:0] dec_kind, dec_peer;
  logic [2*RWAYS-1:0] rcv_way_state;
  logic [2:0] rcv_way;

  int checks = 0, errors = 0;

  bit m_vld [SETS][WAYS];
  bit m_use [SETS][WAYS];
  int m_tag [SETS][WAYS];
  int m_age [SETS][WAYS];

  always #10 clk = ~clk;

  peer_snarf_predictor dut_i (
    .clk(clk), .rst_n(rst_n),
    .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_ready(evict_ready),
    .miss_valid(miss_valid), .miss_addr(miss_addr),
    .snoop_req(snoop_req), .snoop_addr(snoop_addr),
    .rsp_valid(rsp_valid), .rsp_clean(rsp_clean), .rsp_accept(rsp_accept),
    .dec_valid(dec_valid), .dec_kind(dec_kind), .dec_peer(dec_peer),
    .rcv_way_state(rcv_way_state), .rcv_way(rcv_way), .rcv_ok(rcv_ok)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int m_find(input int a);
    int s = a % SETS, t = a >> IDXW;
    for (int w = 0; w < WAYS; w++) if (m_vld[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic void m_miss(input int a);
    int w = m_find(a);
    if (w >= 0) m_use[a % SETS][w] = 1'b1;
  endfunction

  function automatic void m_evict(input int a);
    int s = a % SETS, w = m_find(a), old;
    if (w < 0) begin
      for (int v = WAYS - 1; v >= 0; v--) if (!m_vld[s][v]) w = v;
      if (w < 0) for (int v = 0; v < WAYS; v++) if (m_age[s][v] == WAYS - 1) w = v;
      m_vld[s][w] = 1'b1;
      m_tag[s][w] = a >> IDXW;
      m_use[s][w] = 1'b0;
    end
    old = m_age[s][w];
    for (int v = 0; v < WAYS; v++) begin
      if (v == w) m_age[s][v] = 0;
      else if (m_age[s][v] < old) m_age[s][v]++;
    end
  endfunction

  task automatic miss_only(input int a);
    miss_valid = 1'b1;
    miss_addr  = AW'(a);
    @(negedge clk);
    miss_valid = 1'b0;
    m_miss(a);
  endtask

  // one eviction with snoop collection; called and returning at a negedge
  task automatic run_ev(input int a, input bit cmiss, input int ma,
                        input logic [2:0] cl, input logic [2:0] ac,
                        input int d0, input int d1, input int d2,
                        input bit wmiss, input int wma, input string req);
    int d[3] = '{d0, d1, d2};
    int maxd = 0, ek, ep = 0, ew;
    bit use_b;
    ew = m_find(a);
    use_b = (ew >= 0) && m_use[a % SETS][ew];
    if (cl != 0) ek = 2;
    else if (use_b && ac != 0) begin
      ek = 1;
      for (int p = NPEER - 1; p >= 0; p--) if (ac[p]) ep = p;
    end else ek = 0;
    for (int p = 0; p < NPEER; p++) if (d[p] > maxd) maxd = d[p];

    chk(evict_ready == 1'b1, "R7", "ready before accept", int'(evict_ready), 1);
    evict_valid = 1'b1;
    evict_addr  = AW'(a);
    miss_valid  = cmiss;
    miss_addr   = AW'(ma);
    @(negedge clk);
    evict_valid = 1'b0;
    miss_valid  = 1'b0;
    if (cmiss) m_miss(ma);
    m_evict(a);
    chk(snoop_req == 1'b1, "R8", "snoop_req", int'(snoop_req), 1);
    chk(snoop_addr == AW'(a), "R8", "snoop_addr", int'(snoop_addr), a);
    chk(evict_ready == 1'b0, "R7", "ready while waiting", int'(evict_ready), 0);
    for (int c = 0; c <= maxd; c++) begin
      for (int p = 0; p < NPEER; p++) begin
        rsp_valid[p]  = (d[p] == c);
        rsp_clean[p]  = (d[p] == c) && cl[p];
        rsp_accept[p] = (d[p] == c) && ac[p];
      end
      if (c == 0 && wmiss) begin
        miss_valid = 1'b1;
        miss_addr  = AW'(wma);
      end
      @(negedge clk);
      rsp_valid = '0; rsp_clean = '0; rsp_accept = '0;
      if (c == 0 && wmiss) begin
        miss_valid = 1'b0;
        m_miss(wma);
      end
      if (c == 0) chk(snoop_req == 1'b0, "R8", "snoop_req one cycle", int'(snoop_req), 0);
      if (c < maxd) begin
        chk(evict_ready == 1'b0, "R7", "ready with responses missing", int'(evict_ready), 0);
        chk(dec_valid == 1'b0, "R7", "early decision", int'(dec_valid), 0);
      end
    end
    chk(dec_valid == 1'b1, "R7", "decision strobe", int'(dec_valid), 1);
    chk(evict_ready == 1'b1, "R7", "ready after decision", int'(evict_ready), 1);
    chk(dec_kind == 2'(ek), req, "dec_kind", int'(dec_kind), ek);
    if (ek == 1) chk(dec_peer == 2'(ep), "R12", "dec_peer", int'(dec_peer), ep);
  endtask

  task automatic pick_chk(input logic [2*RWAYS-1:0] st);
    int ew = -1;
    for (int w = RWAYS - 1; w >= 0; w--) if (st[2*w +: 2] == 2'd1) ew = w;
    for (int w = RWAYS - 1; w >= 0; w--) if (st[2*w +: 2] == 2'd0) ew = w;
    rcv_way_state = st;
    #1;
    chk(rcv_ok == (ew >= 0), "R11", "rcv_ok", int'(rcv_ok), int'(ew >= 0));
    if (ew >= 0) chk(rcv_way == 3'(ew), "R11", "rcv_way", int'(rcv_way), ew);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a_ptr = 16'h0105, b_ptr = 16'h0206, c_ptr = 16'h0307;
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_vld[s][w] = 1'b0; m_use[s][w] = 1'b0; m_tag[s][w] = 0; m_age[s][w] = w;
      end
    rst_n = 1'b0;
    evict_valid = 1'b0; miss_valid = 1'b0; evict_addr = '0; miss_addr = '0;
    rsp_valid = '0; rsp_clean = '0; rsp_accept = '0; rcv_way_state = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(evict_ready == 1'b1, "R1", "ready after reset", int'(evict_ready), 1);
    chk(dec_valid == 1'b0, "R1", "dec_valid after reset", int'(dec_valid), 0);
    chk(snoop_req == 1'b0, "R1", "snoop_req after reset", int'(snoop_req), 0);

    // R2 fresh allocation goes to L3, twice
    run_ev(a_ptr, 0, 0, 3'b000, 3'b111, 0, 0, 0, 0, 0, "R2");
    run_ev(a_ptr, 0, 0, 3'b000, 3'b111, 1, 0, 2, 0, 0, "R2");
    // R3 / R12 miss arms the mark, snarf to lowest accepting peer
    miss_only(a_ptr);
    run_ev(a_ptr, 0, 0, 3'b000, 3'b110, 0, 2, 1, 0, 0, "R3");
    // R6 no peer accepts
    run_ev(a_ptr, 0, 0, 3'b000, 3'b000, 0, 0, 0, 0, 0, "R6");
    // R5 clean copy squashes even a marked line
    run_ev(a_ptr, 0, 0, 3'b010, 3'b111, 0, 1, 0, 0, 0, "R5");
    // R4 miss to unknown address has no effect
    miss_only(b_ptr);
    run_ev(b_ptr, 0, 0, 3'b000, 3'b111, 0, 0, 0, 0, 0, "R4");
    run_ev(b_ptr, 0, 0, 3'b000, 3'b111, 0, 0, 0, 0, 0, "R4");
    // R10 same-cycle miss and eviction
    run_ev(c_ptr, 0, 0, 3'b000, 3'b111, 0, 0, 0, 0, 0, "R2");
    run_ev(c_ptr, 1, c_ptr, 3'b000, 3'b111, 0, 0, 0, 0, 0, "R10");
    run_ev(c_ptr, 0, 0, 3'b000, 3'b011, 0, 0, 0, 0, 0, "R10");
    // R9 armed line displaced by LRU replacement in set 3
    run_ev((1 << IDXW) | 3, 0, 0, 3'b000, 3'b111, 0, 0, 0, 0, 0, "R9");
    miss_only((1 << IDXW) | 3);
    for (int t = 2; t <= 5; t++)
      run_ev((t << IDXW) | 3, 0, 0, 3'b000, 3'b111, 0, 0, 0, 0, 0, "R9");
    run_ev((1 << IDXW) | 3, 0, 0, 3'b000, 3'b111, 0, 0, 0, 0, 0, "R9");
    // R7 long spread of responses
    run_ev(c_ptr, 0, 0, 3'b000, 3'b100, 4, 0, 2, 0, 0, "R12");

    // R11 directed picks
    pick_chk({RWAYS{2'd3}});
    pick_chk(16'b11_11_00_11_11_01_11_11);
    pick_chk(16'b10_01_10_10_01_10_10_10);
    pick_chk(16'b11_11_11_00_11_11_00_11);
    pick_chk(16'b01_01_01_01_01_01_01_00);

    // random phase: two crowded sets, mixed misses
    for (int n = 0; n < 250; n++) begin
      int a, ma, wma, k;
      logic [2:0] cl, ac;
      a  = int'(($urandom % 8) << IDXW) | int'($urandom % 2);
      ma = ($urandom % 2) ? a : (int'(($urandom % 8) << IDXW) | int'($urandom % 2));
      wma = int'(($urandom % 8) << IDXW) | int'($urandom % 2);
      k = $urandom % 3;
      for (int i = 0; i < k; i++) miss_only(($urandom % 3 == 0) ? a :
                                  (int'(($urandom % 8) << IDXW) | int'($urandom % 2)));
      cl = ($urandom % 6 == 0) ? 3'($urandom) : 3'b000;
      ac = 3'($urandom);
      run_ev(a, ($urandom % 4 == 0), ma, cl, ac,
             int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
             ($urandom % 3 == 0), wma, (cl != 0) ? "R5" : "R10");
    end
    for (int n = 0; n < 100; n++) pick_chk(16'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule